// File: doc/BRIEF.md
# Bit-Clock Data Link with Transmit/Receive Turnaround

This block carries a modem's serial bit stream to and from a radio transceiver that supplies its own bit clock. The bit clock arrives asynchronously, is synchronised and edge-detected in the system clock domain, and each change of level becomes exactly one event. On falling edges while transmitting, the block pulls one bit from a bit source and drives it on the transmit data line. On rising edges while receiving, and only when duplex operation is off, it samples the receive data line and hands the bit to a bit sink.

The block also times the switchovers between transmit and receive. The transceiver holds a preloaded frequency word that takes effect on a latch-enable pulse. That pulse must land at a safe phase of the bit clock. A transmit request raises push-to-talk at once and pulses latch-enable right after the first bit has been driven. A receive request drops push-to-talk at once and then waits for the falling edge that completes a symbol pair. After a further quarter-bit delay it pulses latch-enable and leaves transmit. A symbol-pair parity flag tracks the 4-level symbol boundaries.

Top module: `bclk_link_turn`

## Requirements
- R1: The bit clock passes through a synchroniser. Each change of its level produces exactly one edge event. A level that is held produces no further events, however long it is held.
- R2: While transmitting, each falling bit-clock edge drives the next source bit on `txd_o`. `src_take_o` pulses for one cycle in that same event when `src_valid_i` is high.
- R3: While not transmitting and with duplex off, each rising bit-clock edge samples `rxd_i`. The sample appears on `sink_bit_o` with a one-cycle `sink_valid_o`. While transmitting, no bits are sampled.
- R4: With `duplex_i` high, no receive bit is delivered.
- R5: `parity_o` is 1 for the even position and 0 for the odd position. It inverts on every driven transmit bit, except the first bit after a transmit request.
- R6: A transmit request (`tx_req_i`, one cycle, while idle) sets `ptt_o` and `tx_active_o` in the next cycle. Latch-enable pulses once right after the first driven bit, and that bit leaves `parity_o` at 0 (odd).
- R7: A receive request sets `ptt_o` low in the next cycle, while transmit stays active. Latch-enable pulses only after a falling edge that moves `parity_o` to 1 (even). The pulse comes a quarter-bit delay of QD system cycles after that edge's event. `tx_active_o` falls together with the pulse.
- R8: After the return to receive, `parity_o` is 0 (odd).
- R9: A falling edge in transmit with `src_valid_i` low drives 0 on `txd_o` and pulses `underrun_o` for one cycle.
- R10: Each latch-enable pulse lasts exactly LATCH_CYC system cycles.
- R11: After reset, `ptt_o`, `latch_o`, `tx_active_o`, `sink_valid_o` and `underrun_o` are low, and `parity_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Transceiver bit clock (asynchronous) |
| duplex_i | input | 1 | Duplex operation; suppresses receive sampling |
| tx_req_i | input | 1 | One-cycle request to switch to transmit |
| rx_req_i | input | 1 | One-cycle request to switch back to receive |
| src_bit_i | input | 1 | Next transmit bit from the bit source |
| src_valid_i | input | 1 | Bit source holds a bit |
| src_take_o | output | 1 | Bit source pop strobe |
| txd_o | output | 1 | Transmit data to the transceiver |
| underrun_o | output | 1 | One-cycle pulse: source empty at a transmit edge |
| rxd_i | input | 1 | Receive data from the transceiver |
| sink_bit_o | output | 1 | Sampled receive bit |
| sink_valid_o | output | 1 | One-cycle strobe for `sink_bit_o` |
| latch_o | output | 1 | Latch-enable pulse for the frequency word |
| ptt_o | output | 1 | Push-to-talk |
| tx_active_o | output | 1 | Block is in transmit |
| parity_o | output | 1 | Symbol-pair position, 1 = even, 0 = odd |

## Verification
The bench issues a receive request at odd and at even parity, so the latch must either follow the very next falling edge or skip one edge. A design that latched on the wrong parity would leave transmit half a symbol early. The bench measures the delay between the falling edge and the latch against QD. A design with no quarter-bit wait, or with the wait counted from the request, misses that window. The bench holds the bit clock at one level for a long time to expose a detector that fires on level rather than change. It runs the bit source dry to show that a zero is driven instead of stale data. It checks that the parity flag is forced to odd both on entry and on exit, and a design that simply kept toggling would break the pair alignment of the next burst.

// File: rtl/bclk_link_pkg.sv
package bclk_link_pkg;

  localparam logic PAR_ODD  = 1'b0;
  localparam logic PAR_EVEN = 1'b1;

  // Quarter-bit wait in system cycles, rounded up, never below one.
  function automatic int unsigned quarter_cycles(input int unsigned clk_khz,
                                                 input int unsigned wait_ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(clk_khz) * longint'(wait_ns);
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  // Parity after a driven bit: the first bit of a burst is always odd.
  function automatic logic next_parity(input logic cur, input logic first_bit);
    return first_bit ? PAR_ODD : ~cur;
  endfunction

endpackage

// File: rtl/bclk_edge.sv
module bclk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], bclk_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign rise_ev = sync_q[MSB] & ~prev_q;
  assign fall_ev = ~sync_q[MSB] & prev_q;

  // R1
  edge_single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !rise_ev);
  // R1
  edge_single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !fall_ev);

endmodule

// File: rtl/bclk_tx_drive.sv
module bclk_tx_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_ev,
  input  logic tx_en,
  input  logic src_bit,
  input  logic src_valid,
  output logic src_take,
  output logic drive_ev,
  output logic txd,
  output logic underrun
);
  assign drive_ev = fall_ev & tx_en;
  assign src_take = drive_ev & src_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd      <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= drive_ev & ~src_valid;
      if (drive_ev) txd <= src_valid & src_bit;
    end
  end

  // R2
  take_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |-> tx_en);
  // R9
  underrun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!$past(src_valid) && !txd));

endmodule

// File: rtl/bclk_rx_sample.sv
module bclk_rx_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic rx_en,
  input  logic rxd,
  output logic sink_bit,
  output logic sink_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sink_bit   <= 1'b0;
      sink_valid <= 1'b0;
    end else begin
      sink_valid <= rise_ev & rx_en;
      if (rise_ev & rx_en) sink_bit <= rxd;
    end
  end

  // R3
  rx_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid |-> $past(rx_en));

endmodule

// File: rtl/bclk_turn_ctl.sv
module bclk_turn_ctl
  import bclk_link_pkg::*;
#(
  parameter int QD        = 1300,
  parameter int LATCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic rx_req,
  input  logic drive_ev,
  output logic tx_active,
  output logic hold,
  output logic ptt,
  output logic latch,
  output logic parity
);
  localparam int DW = (QD < 2) ? 1 : $clog2(QD + 1);
  localparam int LW = (LATCH_CYC < 2) ? 1 : $clog2(LATCH_CYC + 1);
  localparam logic [DW-1:0] QD_V    = DW'(QD);
  localparam logic [LW-1:0] LATCH_V = LW'(LATCH_CYC);

  logic          pend_tx_q, pend_rx_q;
  logic [DW-1:0] dly_q;
  logic [LW-1:0] lcnt_q;
  logic          enter_tx;

  assign enter_tx = tx_req & ~tx_active;
  assign latch    = (lcnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      ptt       <= 1'b0;
      pend_tx_q <= 1'b0;
      pend_rx_q <= 1'b0;
      hold      <= 1'b0;
      dly_q     <= '0;
      lcnt_q    <= '0;
      parity    <= PAR_ODD;
    end else begin
      if (latch) lcnt_q <= lcnt_q - 1'b1;

      if (enter_tx) begin
        ptt       <= 1'b1;
        tx_active <= 1'b1;
        pend_tx_q <= 1'b1;
        pend_rx_q <= 1'b0;
      end else if (rx_req) begin
        ptt <= 1'b0;
        if (tx_active && !pend_tx_q) begin
          pend_rx_q <= 1'b1;
        end else begin
          tx_active <= 1'b0;
          pend_tx_q <= 1'b0;
          parity    <= PAR_ODD;
        end
      end

      if (drive_ev) begin
        parity <= next_parity(parity, pend_tx_q);
        if (pend_tx_q) begin
          pend_tx_q <= 1'b0;
          lcnt_q    <= LATCH_V;
        end else if (pend_rx_q && parity == PAR_ODD) begin
          hold  <= 1'b1;
          dly_q <= QD_V;
        end
      end

      if (hold) begin
        if (dly_q <= DW'(1)) begin
          hold      <= 1'b0;
          tx_active <= 1'b0;
          pend_rx_q <= 1'b0;
          parity    <= PAR_ODD;
          lcnt_q    <= LATCH_V;
        end else begin
          dly_q <= dly_q - 1'b1;
        end
      end
    end
  end

  // R6
  tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_tx |=> (ptt && tx_active));
  // R7
  rx_ptt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !enter_tx) |=> !ptt);
  // R7
  wait_end_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (latch && !tx_active));
  // R8
  exit_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> (parity == PAR_ODD));
  // R5
  parity_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_ev && !pend_tx_q) |=> (parity != $past(parity)));

endmodule

// File: rtl/bclk_link_turn.sv
module bclk_link_turn
  import bclk_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_KHZ     = 50000,
  parameter int QUARTER_NS  = 26000,
  parameter int LATCH_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic duplex_i,
  input  logic tx_req_i,
  input  logic rx_req_i,
  input  logic src_bit_i,
  input  logic src_valid_i,
  output logic src_take_o,
  output logic txd_o,
  output logic underrun_o,
  input  logic rxd_i,
  output logic sink_bit_o,
  output logic sink_valid_o,
  output logic latch_o,
  output logic ptt_o,
  output logic tx_active_o,
  output logic parity_o
);
  localparam int QD = int'(quarter_cycles(CLK_KHZ, QUARTER_NS));

  logic rise_ev, fall_ev, drive_ev, hold, tx_en, rx_en;

  bclk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  assign tx_en = tx_active_o & ~hold;
  assign rx_en = ~tx_active_o & ~duplex_i;

  bclk_tx_drive u_tx (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .tx_en(tx_en),
    .src_bit(src_bit_i), .src_valid(src_valid_i), .src_take(src_take_o),
    .drive_ev(drive_ev), .txd(txd_o), .underrun(underrun_o)
  );

  bclk_rx_sample u_rx (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .rx_en(rx_en),
    .rxd(rxd_i), .sink_bit(sink_bit_o), .sink_valid(sink_valid_o)
  );

  bclk_turn_ctl #(.QD(QD), .LATCH_CYC(LATCH_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req_i), .rx_req(rx_req_i),
    .drive_ev(drive_ev), .tx_active(tx_active_o), .hold(hold),
    .ptt(ptt_o), .latch(latch_o), .parity(parity_o)
  );

  // R4
  duplex_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sink_valid_o |-> !$past(duplex_i));

endmodule

// File: tb/tb_bclk_link_turn.sv
module tb_bclk_link_turn;
  localparam int HP    = 20;   // bit-clock half period in system cycles
  localparam int LATCH = 3;
  localparam int QD    = 10;   // 200 ns at 50 MHz

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, bclk = 1'b0, duplex = 1'b0, tx_req = 1'b0, rx_req = 1'b0, rxd = 1'b0;
  logic src_bit, src_valid, src_take, txd, underrun, sink_bit, sink_valid;
  logic latch, ptt, tx_active, parity;
  bit   bclk_run = 1'b1;
  bit   done = 1'b0;

  int checks = 0, failures = 0;
  int cyc = 0;

  bclk_link_turn #(.SYNC_STAGES(2), .CLK_KHZ(50000), .QUARTER_NS(200), .LATCH_CYC(LATCH)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .duplex_i(duplex),
    .tx_req_i(tx_req), .rx_req_i(rx_req), .src_bit_i(src_bit), .src_valid_i(src_valid),
    .src_take_o(src_take), .txd_o(txd), .underrun_o(underrun), .rxd_i(rxd),
    .sink_bit_o(sink_bit), .sink_valid_o(sink_valid), .latch_o(latch),
    .ptt_o(ptt), .tx_active_o(tx_active), .parity_o(parity)
  );

  always begin
    repeat (HP) @(negedge clk);
    if (bclk_run) bclk = ~bclk;
  end

  always @(posedge clk) cyc++;

  // bit source model
  logic src_bits [0:255];
  int   src_n = 0, src_idx = 0;
  assign src_valid = (src_idx < src_n);
  assign src_bit   = src_bits[src_idx[7:0]];
  always @(posedge clk) if (src_take) src_idx <= src_idx + 1;

  // monitors
  logic rx_log [0:255];
  logic tx_log [0:255];
  int rx_cnt = 0, tx_cnt = 0, und_cnt = 0;
  int latch_rises = 0, latch_run = 0, latch_w = 0, latch_cyc = 0, fall_cyc = 0;
  logic latch_prev = 1'b0;

  always @(negedge clk) begin
    if (sink_valid) begin rx_log[rx_cnt[7:0]] = sink_bit; rx_cnt++; end
    if (underrun) und_cnt++;
    if (latch && !latch_prev) begin latch_rises++; latch_cyc = cyc; end
    if (latch) latch_run++;
    else if (latch_run != 0) begin latch_w = latch_run; latch_run = 0; end
    latch_prev = latch;
  end
  always @(posedge bclk) if (tx_active) begin tx_log[tx_cnt[7:0]] = txd; tx_cnt++; end
  always @(negedge bclk) fall_cyc = cyc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_src(input logic [7:0] pat, input int n);
    for (int i = 0; i < n; i++) src_bits[(src_idx + i) % 256] = pat[i];
    src_n = src_idx + n;
  endtask

  task automatic pulse_tx;
    @(posedge bclk); @(negedge clk);
    tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic pulse_rx;
    @(negedge clk); rx_req = 1'b1; @(negedge clk); rx_req = 1'b0;
  endtask

  task automatic t_reset;
    chk(ptt == 0 && latch == 0 && tx_active == 0, "R11 ptt/latch/tx_active", {ptt, latch, tx_active}, 0);
    chk(sink_valid == 0 && underrun == 0, "R11 sink_valid/underrun", {sink_valid, underrun}, 0);
    chk(parity == 0, "R11 parity", parity, 0);
  endtask

  task automatic t_rx_stream;
    logic [7:0] pat = 8'b1011_0010;
    int s;
    @(negedge bclk);
    s = rx_cnt;
    for (int i = 0; i < 8; i++) begin rxd = pat[i]; @(negedge bclk); end
    repeat (5) @(negedge clk);
    chk(rx_cnt - s == 8, "R3 rx count", rx_cnt - s, 8);
    for (int i = 0; i < 8; i++)
      chk(rx_log[(s + i) % 256] == pat[i], "R3 rx bit", rx_log[(s + i) % 256], pat[i]);
  endtask

  task automatic t_duplex;
    int s;
    @(negedge bclk); duplex = 1'b1;
    s = rx_cnt;
    repeat (4) @(posedge bclk);
    repeat (5) @(negedge clk);
    chk(rx_cnt == s, "R4 duplex rx count", rx_cnt - s, 0);
    @(negedge bclk); duplex = 1'b0;
  endtask

  task automatic t_hold;
    int s;
    @(posedge bclk);
    s = rx_cnt;
    bclk_run = 1'b0;
    repeat (200) @(negedge clk);
    chk(rx_cnt == s + 1, "R1 held level events", rx_cnt - s, 1);
    bclk_run = 1'b1;
  endtask

  task automatic t_tx_burst_odd_exit;
    logic [7:0] pat = 8'b0100_1101;
    int ts, ls, rs, us, d;
    load_src(pat, 8);
    ts = tx_cnt; ls = latch_rises; rs = rx_cnt; us = und_cnt;
    pulse_tx();
    chk(ptt == 1 && tx_active == 1, "R6 ptt/tx_active on request", {ptt, tx_active}, 3);
    @(negedge bclk); repeat (4 + LATCH) @(negedge clk);
    chk(latch_rises == ls + 1, "R6 latch after first bit", latch_rises - ls, 1);
    chk(latch_w == LATCH, "R10 latch width", latch_w, LATCH);
    chk(parity == 0, "R6 first bit odd", parity, 0);
    @(negedge bclk); repeat (4) @(negedge clk);
    chk(parity == 1, "R5 parity toggles", parity, 1);
    repeat (6) @(negedge bclk);
    @(posedge bclk); repeat (2) @(negedge clk);
    chk(tx_cnt - ts == 8, "R2 tx bit count", tx_cnt - ts, 8);
    for (int i = 0; i < 8; i++)
      chk(tx_log[(ts + i) % 256] == pat[i], "R2 tx bit", tx_log[(ts + i) % 256], pat[i]);
    chk(src_idx == src_n, "R2 source drained", src_idx, src_n);
    chk(rx_cnt == rs, "R3 no rx during tx", rx_cnt - rs, 0);
    chk(und_cnt == us, "R9 no early underrun", und_cnt - us, 0);
    @(negedge bclk); repeat (5) @(negedge clk);
    chk(und_cnt == us + 1, "R9 underrun pulse", und_cnt - us, 1);
    chk(parity == 0, "R5 parity after ninth bit", parity, 0);
    @(posedge bclk); repeat (2) @(negedge clk);
    chk(tx_log[(tx_cnt - 1) % 256] == 1'b0, "R9 zero driven", tx_log[(tx_cnt - 1) % 256], 0);
    pulse_rx();
    chk(ptt == 0, "R7 ptt drops on request", ptt, 0);
    chk(tx_active == 1, "R7 tx held until latch", tx_active, 1);
    ls = latch_rises;
    @(negedge bclk); repeat (QD + 6) @(negedge clk);
    chk(latch_rises == ls + 1, "R7 latch on even edge", latch_rises - ls, 1);
    d = latch_cyc - fall_cyc;
    chk(d >= QD + 2 && d <= QD + 4, "R7 quarter delay", d, QD + 3);
    chk(tx_active == 0, "R7 left transmit", tx_active, 0);
    chk(parity == 0, "R8 parity odd after return", parity, 0);
    chk(latch_w == LATCH, "R10 exit latch width", latch_w, LATCH);
    rs = rx_cnt;
    repeat (2) @(posedge bclk);
    repeat (5) @(negedge clk);
    chk(rx_cnt == rs + 2, "R3 rx resumes", rx_cnt - rs, 2);
  endtask

  task automatic t_tx_burst_even_request;
    int ls, us;
    load_src(8'b0000_0110, 4);
    us = und_cnt;
    pulse_tx();
    @(negedge bclk); @(negedge bclk);
    @(posedge bclk); repeat (2) @(negedge clk);
    chk(parity == 1, "R5 even after two bits", parity, 1);
    pulse_rx();
    ls = latch_rises;
    @(negedge bclk); repeat (QD + 6) @(negedge clk);
    chk(latch_rises == ls, "R7 no latch on odd edge", latch_rises - ls, 0);
    chk(tx_active == 1, "R7 still transmitting", tx_active, 1);
    @(negedge bclk); repeat (QD + 6) @(negedge clk);
    chk(latch_rises == ls + 1, "R7 latch on next even edge", latch_rises - ls, 1);
    chk(tx_active == 0, "R7 left transmit", tx_active, 0);
    chk(parity == 0, "R8 parity odd after return", parity, 0);
    chk(und_cnt == us, "R9 no underrun with full source", und_cnt - us, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_stream();
    t_duplex();
    t_hold();
    t_tx_burst_odd_exit();
    t_tx_burst_even_request();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule